// File: doc/BRIEF.md
# Link Speed Retrain Sequencer

After reset this block decides once whether a link that trained at the slowest signalling rate should be retrained. The port may support a faster rate. If the link is up, the port advertises a maximum speed above the slowest one, and the link currently runs at the slowest speed, the sequencer writes the link control field back with its retrain bit set. It then waits in two separately timed phases. In the first it waits for the link-training flag to drop. In the second it waits for the training state to return to the active state. In both phases it samples status only on a fixed poll interval. The block only makes decisions and issues a single write strobe. The control register and the physical layer belong to the surrounding logic.

The sequence starts on the first clock edge after reset is released and visits these states: `ST_LINK` (is the link up?), `ST_CAP` (can the port go faster?), `ST_SPEED` (is it at the slowest rate?), `ST_WRITE` (one-cycle control write), `ST_TRAIN` (wait for training to end), `ST_RETURN` (wait for the active state) and `ST_DONE`, which is terminal until the next reset. Transitions: `ST_LINK`→`ST_DONE` when the link is down, else →`ST_CAP`. `ST_CAP`→`ST_DONE` when the speed field is at most 1, else →`ST_SPEED`. `ST_SPEED`→`ST_DONE` when the current speed is not 1, else →`ST_WRITE`. `ST_WRITE`→`ST_TRAIN` always. `ST_TRAIN`→`ST_RETURN` on a poll that sees training clear, or on expiry. `ST_RETURN`→`ST_DONE` on a poll that sees the link up, or on expiry.

A timeout sets a sticky flag but does not stop the sequence. It continues to `ST_DONE`.

Top module: `lrs_retrain_seq`

## Requirements
- R1: The link counts as up only when the 5-bit training state equals 5'h0F. Any other code, including 5'h0E and 5'h1F, counts as down.
- R2: If the link is down on the first edge after reset release, `done` rises on that edge. No write is issued and both timeout flags stay 0.
- R3: If the supported-speed field `link_cap[3:0]` is 0 or 1, `done` rises on the second edge and no write is issued. A value of 2 or more continues the sequence.
- R4: If the current-speed field `link_status[3:0]` is not 1, `done` rises on the third edge and no write is issued.
- R5: When a retrain is due, `ctrl_wr_en` is high for exactly the cycle after the third edge. `ctrl_wr_data` equals `link_ctrl` with bit 5 forced to 1 and every other bit unchanged.
- R6: The training wait ends at the first poll instant that sees `link_status[11]` low. If no poll sees it low within `TRAIN_LIMIT` edges, the wait ends on that edge and `train_timeout` is set.
- R7: Within each wait phase, status is sampled only on every `POLL_CYCLES`-th edge counted from entry to the phase, not on every edge.
- R8: The return wait ends at the first poll instant that sees the training state equal to 5'h0F. If none does within `RETURN_LIMIT` edges, the wait ends on that edge and `return_timeout` is set. `done` then follows on that same edge.
- R9: `busy` is high and `done` low from reset until the sequence ends. After that, `done`, `busy` and both timeout flags hold their values until the next reset. During reset the outputs read busy=1, done=0, write=0 and flags=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the sequence |
| ltssm_state | input | 5 | Current link training state code |
| link_cap | input | 16 | Link capabilities field; bits [3:0] hold the maximum supported speed |
| link_status | input | 16 | Link status field; bits [3:0] hold the current speed, bit 11 is the training flag |
| link_ctrl | input | 16 | Present contents of link control, used for the read-modify-write |
| ctrl_wr_en | output | 1 | One-cycle write strobe for link control |
| ctrl_wr_data | output | 16 | Value to write: link control with the retrain bit (5) set |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (terminal until reset) |
| train_timeout | output | 1 | Sticky: training flag did not clear in time |
| return_timeout | output | 1 | Sticky: link did not return to the active state in time |

## Verification
Counting edges from reset release, the results fall due as follows. A down link gives `done` on edge 1. A slow-only port gives it on edge 2. A link not at the slowest rate gives it on edge 3. The write strobe is due after edge 3. Each wait phase ends after a multiple of `POLL_CYCLES` edges, or exactly at its limit. With the defaults, the clean retrain finishes on edge 12, a stuck training flag on edge 28, and a fully stuck link on edge 48. The bench counts edges from release and samples on the falling clock edge. It computes each expected edge from the poll and limit parameters and from the cycle at which the stimulus changes the status inputs. The scoreboard compares the recorded write cycle, write data, `done` cycle and flags against those numbers, then checks again five cycles later that everything has held.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    localparam int unsigned REG_W        = 16;
    localparam int unsigned STATE_W      = 5;
    localparam int unsigned SPEED_W      = 4;
    localparam logic [STATE_W-1:0] ACTIVE_CODE = 5'h0F;
    localparam logic [SPEED_W-1:0] SLOWEST_SPEED = 4'd1;
    localparam int unsigned RETRAIN_BIT  = 5;
    localparam int unsigned TRAINING_BIT = 11;

    typedef enum logic [2:0] {
        ST_LINK   = 3'd0,
        ST_CAP    = 3'd1,
        ST_SPEED  = 3'd2,
        ST_WRITE  = 3'd3,
        ST_TRAIN  = 3'd4,
        ST_RETURN = 3'd5,
        ST_DONE   = 3'd6
    } lrs_state_e;

endpackage

// File: rtl/lrs_link_decode.sv
module lrs_link_decode
    import lrs_pkg::*;
(
    input  logic [STATE_W-1:0] ltssm_state,
    input  logic [REG_W-1:0]   link_cap,
    input  logic [REG_W-1:0]   link_status,
    output logic               link_up,
    output logic               can_go_faster,
    output logic               at_slowest,
    output logic               training
);

    // Only the exact active code means the link is up (R1).
    always_comb begin
        link_up       = (ltssm_state == ACTIVE_CODE);
        can_go_faster = (link_cap[SPEED_W-1:0] > SLOWEST_SPEED);
        at_slowest    = (link_status[SPEED_W-1:0] == SLOWEST_SPEED);
        training      = link_status[TRAINING_BIT];
    end

endmodule

// File: rtl/lrs_wait_timer.sv
module lrs_wait_timer #(
    parameter int unsigned POLL_CYCLES  = 4,
    parameter int unsigned LIMIT_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic poll_tick,
    output logic expired
);

    localparam int unsigned PW = (POLL_CYCLES  > 1) ? $clog2(POLL_CYCLES  + 1) : 1;
    localparam int unsigned TW = (LIMIT_CYCLES > 1) ? $clog2(LIMIT_CYCLES + 1) : 1;
    localparam logic [PW-1:0] POLL_LOAD = PW'(POLL_CYCLES - 1);
    localparam logic [TW-1:0] LIMIT_LAST = TW'(LIMIT_CYCLES - 1);

    logic [PW-1:0] poll_cnt;
    logic [TW-1:0] age_cnt;

    // Counters rest at their load values whenever the phase is not active,
    // so each phase starts a fresh poll interval and a fresh age.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_cnt <= POLL_LOAD;
            age_cnt  <= '0;
        end else if (!run) begin
            poll_cnt <= POLL_LOAD;
            age_cnt  <= '0;
        end else begin
            poll_cnt <= (poll_cnt == '0) ? POLL_LOAD : poll_cnt - 1'b1;
            if (age_cnt != LIMIT_LAST) begin
                age_cnt <= age_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        poll_tick = run && (poll_cnt == '0);
        expired   = run && (age_cnt == LIMIT_LAST);
    end

    // R7: with an interval above one, two polls never land on adjacent edges.
    generate
        if (POLL_CYCLES > 1) begin : g_gap
            assert_poll_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
                poll_tick |=> !poll_tick);
            assert_entry_no_poll_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (run && !$past(run)) |-> !poll_tick);
        end
    endgenerate

endmodule

// File: rtl/lrs_retrain_seq.sv
module lrs_retrain_seq
    import lrs_pkg::*;
#(
    parameter int unsigned POLL_CYCLES  = 4,
    parameter int unsigned TRAIN_LIMIT  = 20,
    parameter int unsigned RETURN_LIMIT = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [4:0]         ltssm_state,
    input  logic [15:0]        link_cap,
    input  logic [15:0]        link_status,
    input  logic [15:0]        link_ctrl,
    output logic               ctrl_wr_en,
    output logic [15:0]        ctrl_wr_data,
    output logic               busy,
    output logic               done,
    output logic               train_timeout,
    output logic               return_timeout
);

    lrs_state_e state, state_nxt;

    logic link_up, can_go_faster, at_slowest, training;
    logic trn_tick, trn_exp, ret_tick, ret_exp;
    logic trn_run, ret_run;
    logic trn_ok, ret_ok;
    logic trn_to_set, ret_to_set;

    lrs_link_decode u_decode (
        .ltssm_state   (ltssm_state),
        .link_cap      (link_cap),
        .link_status   (link_status),
        .link_up       (link_up),
        .can_go_faster (can_go_faster),
        .at_slowest    (at_slowest),
        .training      (training)
    );

    assign trn_run = (state == ST_TRAIN);
    assign ret_run = (state == ST_RETURN);

    lrs_wait_timer #(
        .POLL_CYCLES  (POLL_CYCLES),
        .LIMIT_CYCLES (TRAIN_LIMIT)
    ) u_train_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (trn_run),
        .poll_tick (trn_tick),
        .expired   (trn_exp)
    );

    lrs_wait_timer #(
        .POLL_CYCLES  (POLL_CYCLES),
        .LIMIT_CYCLES (RETURN_LIMIT)
    ) u_return_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ret_run),
        .poll_tick (ret_tick),
        .expired   (ret_exp)
    );

    // A successful poll on the expiry edge wins over the timeout.
    assign trn_ok     = trn_tick && !training;
    assign ret_ok     = ret_tick && link_up;
    assign trn_to_set = trn_run && trn_exp && !trn_ok;
    assign ret_to_set = ret_run && ret_exp && !ret_ok;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_LINK:   state_nxt = link_up       ? ST_CAP   : ST_DONE;
            ST_CAP:    state_nxt = can_go_faster ? ST_SPEED : ST_DONE;
            ST_SPEED:  state_nxt = at_slowest    ? ST_WRITE : ST_DONE;
            ST_WRITE:  state_nxt = ST_TRAIN;
            ST_TRAIN:  state_nxt = (trn_ok || trn_exp) ? ST_RETURN : ST_TRAIN;
            ST_RETURN: state_nxt = (ret_ok || ret_exp) ? ST_DONE   : ST_RETURN;
            ST_DONE:   state_nxt = ST_DONE;
            default:   state_nxt = ST_DONE;
        endcase
    end

    // State register and sticky timeout flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state          <= ST_LINK;
            train_timeout  <= 1'b0;
            return_timeout <= 1'b0;
        end else begin
            state <= state_nxt;
            if (trn_to_set) train_timeout  <= 1'b1;
            if (ret_to_set) return_timeout <= 1'b1;
        end
    end

    // Output decode.
    always_comb begin
        ctrl_wr_en   = 1'b0;
        ctrl_wr_data = '0;
        busy         = 1'b1;
        done         = 1'b0;
        unique case (state)
            ST_WRITE: begin
                ctrl_wr_en   = 1'b1;
                ctrl_wr_data = link_ctrl;
                ctrl_wr_data[RETRAIN_BIT] = 1'b1;
            end
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assert_linkdown_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LINK && ltssm_state != ACTIVE_CODE) |=> (done && !ctrl_wr_en));

    assert_cap_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAP && link_cap[3:0] <= 4'd1) |=> done);

    assert_write_needs_slowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_en |-> ($past(link_status[3:0]) == 4'd1));

    assert_write_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_en |=> !ctrl_wr_en);

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_train_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        train_timeout |=> train_timeout);

    assert_return_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        return_timeout |=> return_timeout);

endmodule

// File: tb/lrs_retrain_seq_test.sv
module lrs_retrain_seq_test;

    localparam int POLL = 4;
    localparam int TLIM = 20;
    localparam int RLIM = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ltssm_state = 5'h0F;
    logic [15:0] link_cap = 16'h0;
    logic [15:0] link_status = 16'h0;
    logic [15:0] link_ctrl = 16'h0;
    logic        ctrl_wr_en;
    logic [15:0] ctrl_wr_data;
    logic        busy, done, train_timeout, return_timeout;

    always #2.5 clk = ~clk;

    lrs_retrain_seq #(
        .POLL_CYCLES  (POLL),
        .TRAIN_LIMIT  (TLIM),
        .RETURN_LIMIT (RLIM)
    ) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ltssm_state    (ltssm_state),
        .link_cap       (link_cap),
        .link_status    (link_status),
        .link_ctrl      (link_ctrl),
        .ctrl_wr_en     (ctrl_wr_en),
        .ctrl_wr_data   (ctrl_wr_data),
        .busy           (busy),
        .done           (done),
        .train_timeout  (train_timeout),
        .return_timeout (return_timeout)
    );

    typedef struct {
        string req;
        int    wr_cnt;
        int    wr_cyc;
        int    wr_data;
        int    done_cyc;
        int    trn_to;
        int    ret_to;
    } exp_t;

    exp_t sb_q[$];
    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int wr_cnt = 0;
    int wr_cyc = -1;
    int wr_data = 0;
    bit done_seen = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    // Monitor: counts edges since release, records writes, scores on done.
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; wr_cnt = 0; wr_cyc = -1; done_seen = 0;
        end else begin
            cyc++;
            if (ctrl_wr_en) begin
                wr_cnt++; wr_cyc = cyc; wr_data = int'(ctrl_wr_data);
            end
            if (done && !done_seen) begin
                done_seen = 1;
                if (sb_q.size() == 0) begin
                    chk("R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(e.req, "done cycle", cyc, e.done_cyc);
                    chk(e.req, "write count", wr_cnt, e.wr_cnt);
                    if (e.wr_cnt > 0) begin
                        chk("R5", "write cycle", wr_cyc, e.wr_cyc);
                        chk("R5", "write data", wr_data, e.wr_data);
                    end
                    chk(e.req, "train_timeout", int'(train_timeout), e.trn_to);
                    chk(e.req, "return_timeout", int'(return_timeout), e.ret_to);
                end
            end
        end
    end

    // Poll phase model: number of edges spent in a phase that starts after
    // edge 'start'; 'ok_from' is the first edge seeing the success condition
    // (-1 never). Returns the edge count and whether it timed out.
    function automatic int phase_len(int start, int ok_from, int limit, output int to);
        to = 0;
        for (int n = 1; n <= limit; n++) begin
            if ((n % POLL == 0) && ok_from >= 0 && (start + n) >= ok_from) return n;
        end
        to = 1;
        return limit;
    endfunction

    // Driver: computes the expectation, pushes it, runs one sequence.
    // clr_after: training flag clears after this cycle (0 = clear at start, -1 never).
    // drop: state code leaves the active code after cycle 3.
    // ret_after: state code returns after this cycle (-1 never).
    task automatic run_case(string req, logic [4:0] st, logic [3:0] cap, logic [3:0] spd,
                            logic [15:0] ctl, int clr_after, bit drop, int ret_after);
        exp_t e;
        int t_len, r_len, t_to, r_to, n;
        bit timed_out;
        e.req = req; e.wr_cnt = 0; e.wr_cyc = -1; e.wr_data = 0; e.trn_to = 0; e.ret_to = 0;
        if (st != 5'h0F)         e.done_cyc = 1;
        else if (cap <= 4'd1)    e.done_cyc = 2;
        else if (spd != 4'd1)    e.done_cyc = 3;
        else begin
            e.wr_cnt = 1; e.wr_cyc = 3; e.wr_data = int'(ctl | 16'h0020);
            t_len = phase_len(4, (clr_after < 0) ? -1 : clr_after + 1, TLIM, t_to);
            r_len = phase_len(4 + t_len, drop ? ((ret_after < 0) ? -1 : ret_after + 1) : 0, RLIM, r_to);
            e.done_cyc = 4 + t_len + r_len;
            e.trn_to = t_to; e.ret_to = r_to;
        end
        sb_q.push_back(e);

        rst_n = 1'b0;
        ltssm_state = st;
        link_cap = {12'h0, cap};
        link_ctrl = ctl;
        link_status = {4'h0, (clr_after == 0) ? 1'b0 : 1'b1, 7'h0, spd};
        repeat (2) @(negedge clk);
        #1;
        // Reset state (R9)
        chk("R9", "reset busy", int'(busy), 1);
        chk("R9", "reset done", int'(done), 0);
        chk("R9", "reset write", int'(ctrl_wr_en), 0);
        chk("R9", "reset flags", int'({train_timeout, return_timeout}), 0);
        rst_n = 1'b1;
        n = 0;
        timed_out = 0;
        while (!done_seen) begin
            @(negedge clk);
            #1;
            if (drop && cyc == 3) ltssm_state = 5'h0B;
            if (drop && ret_after >= 0 && cyc == ret_after) ltssm_state = 5'h0F;
            if (clr_after > 0 && cyc == clr_after) link_status[11] = 1'b0;
            n++;
            if (n > 150) begin
                chk(req, "case watchdog", 1, 0);
                timed_out = 1;
                void'(sb_q.pop_front());
                break;
            end
        end
        if (!timed_out) begin
            repeat (5) @(negedge clk);
            #1;
            chk("R9", "done held", int'(done), 1);
            chk("R9", "busy low after done", int'(busy), 0);
            chk("R9", "flags held", int'({train_timeout, return_timeout}), (e.trn_to << 1) | e.ret_to);
            chk("R9", "no late write", wr_cnt, e.wr_cnt);
        end
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1, R2: near-miss state codes count as down.
        run_case("R1", 5'h0E, 4'd3, 4'd1, 16'h0041, 0, 0, -1);
        run_case("R2", 5'h1F, 4'd3, 4'd1, 16'h0041, 0, 0, -1);
        // R3: slowest-only ports.
        run_case("R3", 5'h0F, 4'd1, 4'd1, 16'h0041, 0, 0, -1);
        run_case("R3", 5'h0F, 4'd0, 4'd1, 16'h0041, 0, 0, -1);
        // R4: not at the slowest rate.
        run_case("R4", 5'h0F, 4'd3, 4'd2, 16'h0041, 0, 0, -1);
        // R5: clean retrains, cap boundary at 2, varied control values.
        run_case("R5", 5'h0F, 4'd2, 4'd1, 16'h0041, 0, 0, -1);
        run_case("R5", 5'h0F, 4'd3, 4'd1, 16'hFFDF, 0, 0, -1);
        run_case("R5", 5'h0F, 4'd4, 4'd1, 16'h0020, 0, 0, -1);
        // R6: training flag never clears.
        run_case("R6", 5'h0F, 4'd3, 4'd1, 16'h0000, -1, 0, -1);
        // R7: training flag clears after cycle 9; next poll at edge 12.
        run_case("R7", 5'h0F, 4'd3, 4'd1, 16'h0000, 9, 0, -1);
        run_case("R7", 5'h0F, 4'd3, 4'd1, 16'h0000, 12, 0, -1);
        // R8: link leaves active state, returns late or never.
        run_case("R8", 5'h0F, 4'd3, 4'd1, 16'h0000, 0, 1, 17);
        run_case("R8", 5'h0F, 4'd3, 4'd1, 16'h0000, 0, 1, -1);
        // R6 and R8 together: both phases time out.
        run_case("R8", 5'h0F, 4'd3, 4'd1, 16'h0000, -1, 1, -1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule